// File: doc/BRIEF.md
# Interrupt Source PQ State Buffer

This block holds a two-bit coalescing state for each of a bank of interrupt sources. The upper bit (P) says an event has been forwarded and not yet completed. The lower bit (Q) says a further event arrived meanwhile. Software reaches the bank through a memory-mapped window of 8-byte loads and stores. The source number is taken from the address bits above the page shift, and the operation is chosen by the low 12-bit offset. Hardware reaches it through a single trigger port that carries a source number and a line level.

Each source is either message-signalled or level-sensitive, as set by a per-source mode input. Whenever an access or a trigger must be forwarded for routing, the block raises a one-cycle notification that carries the source number. Bus accesses and hardware triggers each have their own notification channel, so both can report in the same cycle. In two-page mode, the page selected by the address bit just below the page shift splits the window in two. The even page only triggers. The odd page carries end-of-interrupt (EOI), state reads and state writes.

Top module: `pq_source_bank`

## Requirements
- R1: After reset every source is off (P=0, Q=1, read back as 1), and no read or notification output is valid.
- R2: A trigger takes reset (00) to pending (10) and forwards a notification. It takes pending or queued (11) to queued with no notification. It leaves off (01) unchanged with no notification. A store at management-page offsets 0x000–0x3FF is a trigger, and no notification is issued without an access.
- R3: An EOI takes reset or pending to reset with no notification. It takes queued to pending and forwards a notification. It leaves off unchanged.
- R4: A load at management offsets 0x000–0x7FF performs an EOI and returns 1 when it forwarded a notification, else 0.
- R5: A load at management offsets 0x800–0xBFF returns the state in bits [1:0] and changes nothing.
- R6: A load at offsets 0xC00–0xFFF returns the old state and writes offset bits [9:8] as the new state. A store in that range writes the state the same way.
- R7: With store-EOI enabled, a store at 0x400–0x7FF is an EOI. With it disabled, such a store is ignored. A store at 0x800–0xBFF is always ignored.
- R8: In two-page mode, address bit PAGE_SHIFT-1 = 0 selects the trigger page. Any store there is a trigger whatever the offset, and any load there returns all ones and changes nothing.
- R9: An access whose size is not 8 bytes is ignored when it is a store, and returns all ones when it is a load.
- R10: For a level-sensitive source, a hardware input with level 1 sets the source's asserted flag and triggers only from reset (00 to 10, with a notification). A level-0 input clears the flag. An EOI that leaves the flag set re-runs that level trigger.
- R11: For a message-signalled source, a hardware input with level 1 is a trigger, and level 0 has no effect.
- R12: When a bus access and a hardware trigger hit the same source in one cycle, the bus access is applied first and the trigger acts on its result.
- R13: Load data and both notifications appear in the cycle after the access or trigger that caused them, and each is valid for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lsi_mode | input | NUM_SRC | Per-source mode: 1 = level-sensitive, 0 = message-signalled |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_write | input | 1 | 1 = store, 0 = load |
| bus_addr | input | SRC_W+PAGE_SHIFT | Access address |
| bus_bytes | input | 4 | Access size in bytes (only 8 is legal) |
| rd_valid | output | 1 | Load data valid |
| rd_data | output | 64 | Load data |
| bus_ntf_valid | output | 1 | Notification caused by a bus access |
| bus_ntf_src | output | SRC_W | Source of the bus notification |
| hw_valid | input | 1 | Hardware trigger present this cycle |
| hw_src | input | SRC_W | Source of the hardware trigger |
| hw_level | input | 1 | Line level of the hardware trigger |
| hw_ntf_valid | output | 1 | Notification caused by a hardware trigger |
| hw_ntf_src | output | SRC_W | Source of the hardware notification |

## Verification
A bus access and a hardware trigger can land on the same source in the same cycle. The bench provokes this in three ways: an EOI load on a reset source, a state-setting store on a pending source, and a bus trigger paired with a hardware trigger on a different source. The second case tells the two orders apart. Applying the store first and then the trigger ends in pending with a hardware notification. The reverse order would end in reset with none. Each case is judged by which channel reports, by the load data, and by a state read taken right after.

// File: rtl/pqsb_pkg.sv
`timescale 1ns/1ps
package pqsb_pkg;

  typedef enum logic [1:0] {
    PQ_RESET  = 2'b00,
    PQ_OFF    = 2'b01,
    PQ_PEND   = 2'b10,
    PQ_QUEUED = 2'b11
  } pq_t;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_TRIG,
    OP_EOI,
    OP_GET,
    OP_SET,
    OP_BAD
  } op_t;

  typedef struct packed {
    pq_t  pq;
    logic ntf;
  } step_t;

  // event arrival
  function automatic step_t pq_trigger(pq_t s);
    case (s)
      PQ_RESET:            return '{pq: PQ_PEND,   ntf: 1'b1};
      PQ_PEND, PQ_QUEUED:  return '{pq: PQ_QUEUED, ntf: 1'b0};
      default:             return '{pq: s,         ntf: 1'b0};
    endcase
  endfunction

  // completion
  function automatic step_t pq_eoi(pq_t s);
    case (s)
      PQ_RESET, PQ_PEND:   return '{pq: PQ_RESET, ntf: 1'b0};
      PQ_QUEUED:           return '{pq: PQ_PEND,  ntf: 1'b1};
      default:             return '{pq: s,        ntf: 1'b0};
    endcase
  endfunction

  // level line trigger: fires only from an idle source, never sets Q
  function automatic step_t pq_level(pq_t s);
    if (s == PQ_RESET) return '{pq: PQ_PEND, ntf: 1'b1};
    return '{pq: s, ntf: 1'b0};
  endfunction

endpackage

// File: rtl/pqsb_decode.sv
`timescale 1ns/1ps
module pqsb_decode
  import pqsb_pkg::*;
#(
  parameter int NUM_SRC    = 16,
  parameter int SRC_W      = 4,
  parameter int PAGE_SHIFT = 13,
  parameter int ADDR_W     = 17,
  parameter bit TWO_PAGE   = 1'b1,
  parameter bit STORE_EOI  = 1'b1
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        bytes,
  output op_t               op,
  output logic [SRC_W-1:0]  src,
  output pq_t               setv
);

  localparam logic [SRC_W:0] NSRC = NUM_SRC[SRC_W:0];

  logic        legal;
  logic        trig_page;
  logic [11:0] off;

  assign src       = addr[ADDR_W-1:PAGE_SHIFT];
  assign off       = addr[11:0];
  assign trig_page = TWO_PAGE && !addr[PAGE_SHIFT-1];
  assign legal     = (bytes == 4'd8) && ({1'b0, src} < NSRC);
  assign setv      = pq_t'(off[9:8]);

  always_comb begin
    op = OP_NONE;
    if (valid) begin
      if (!legal) begin
        op = write ? OP_NONE : OP_BAD;
      end else if (write) begin
        if (trig_page) op = OP_TRIG;
        else begin
          case (off[11:10])
            2'b00:   op = OP_TRIG;
            2'b01:   op = STORE_EOI ? OP_EOI : OP_NONE;
            2'b10:   op = OP_NONE;
            default: op = OP_SET;
          endcase
        end
      end else begin
        if (trig_page) op = OP_BAD;
        else begin
          case (off[11:10])
            2'b00, 2'b01: op = OP_EOI;
            2'b10:        op = OP_GET;
            default:      op = OP_SET;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/pqsb_cell.sv
`timescale 1ns/1ps
module pqsb_cell
  import pqsb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lsi,
  input  logic       bus_hit,
  input  op_t        bus_op,
  input  pq_t        bus_setv,
  input  logic       hw_hit,
  input  logic       hw_level,
  output logic [1:0] pq_out,
  output logic       bus_ntf,
  output logic       hw_ntf
);

  pq_t   pq_q, pq_b, pq_d;
  logic  asrt_q, asrt_d;
  step_t st_b, st_h;

  always_comb begin
    pq_b    = pq_q;
    bus_ntf = 1'b0;
    st_b    = '{pq: pq_q, ntf: 1'b0};
    if (bus_hit) begin
      case (bus_op)
        OP_TRIG: begin
          st_b    = pq_trigger(pq_q);
          pq_b    = st_b.pq;
          bus_ntf = st_b.ntf;
        end
        OP_EOI: begin
          st_b    = pq_eoi(pq_q);
          pq_b    = st_b.pq;
          bus_ntf = st_b.ntf;
          if (lsi && asrt_q) begin
            st_b    = pq_level(pq_b);
            pq_b    = st_b.pq;
            bus_ntf = st_b.ntf;
          end
        end
        OP_SET:  pq_b = bus_setv;
        default: ;
      endcase
    end
  end

  // hardware trigger acts on the bus result
  always_comb begin
    pq_d   = pq_b;
    asrt_d = asrt_q;
    hw_ntf = 1'b0;
    st_h   = '{pq: pq_b, ntf: 1'b0};
    if (hw_hit) begin
      if (lsi) begin
        asrt_d = hw_level;
        if (hw_level) st_h = pq_level(pq_b);
      end else if (hw_level) begin
        st_h = pq_trigger(pq_b);
      end
      pq_d   = st_h.pq;
      hw_ntf = st_h.ntf;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pq_q   <= PQ_OFF;
      asrt_q <= 1'b0;
    end else begin
      pq_q   <= pq_d;
      asrt_q <= asrt_d;
    end
  end

  assign pq_out = pq_q;

endmodule

// File: rtl/pq_source_bank.sv
`timescale 1ns/1ps
module pq_source_bank
  import pqsb_pkg::*;
#(
  parameter int NUM_SRC    = 16,
  parameter int PAGE_SHIFT = 13,
  parameter bit TWO_PAGE   = 1'b1,
  parameter bit STORE_EOI  = 1'b1,
  localparam int SRC_W     = $clog2(NUM_SRC),
  localparam int ADDR_W    = SRC_W + PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_SRC-1:0] lsi_mode,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_bytes,
  output logic              rd_valid,
  output logic [63:0]       rd_data,
  output logic              bus_ntf_valid,
  output logic [SRC_W-1:0]  bus_ntf_src,
  input  logic              hw_valid,
  input  logic [SRC_W-1:0]  hw_src,
  input  logic              hw_level,
  output logic              hw_ntf_valid,
  output logic [SRC_W-1:0]  hw_ntf_src
);

  localparam int SLOTS = 2 ** SRC_W;
  localparam logic [SRC_W:0] NSRC = NUM_SRC[SRC_W:0];

  op_t              dec_op;
  logic [SRC_W-1:0] dec_src;
  pq_t              dec_setv;
  logic             bus_act;
  logic             hw_ok;
  logic             coll_same;
  logic [1:0]       pq_all   [SLOTS];
  logic             bntf_all [SLOTS];
  logic [SLOTS-1:0] hntf_vec;
  logic [1:0]       sel_pq;
  logic             sel_bntf;
  logic [63:0]      ld_data;

  pqsb_decode #(
    .NUM_SRC(NUM_SRC), .SRC_W(SRC_W), .PAGE_SHIFT(PAGE_SHIFT),
    .ADDR_W(ADDR_W), .TWO_PAGE(TWO_PAGE), .STORE_EOI(STORE_EOI)
  ) u_dec (
    .valid(bus_valid), .write(bus_write), .addr(bus_addr), .bytes(bus_bytes),
    .op(dec_op), .src(dec_src), .setv(dec_setv)
  );

  assign bus_act   = (dec_op == OP_TRIG) || (dec_op == OP_EOI) || (dec_op == OP_SET);
  assign hw_ok     = hw_valid && ({1'b0, hw_src} < NSRC);
  assign coll_same = bus_act && hw_ok && (dec_src == hw_src);

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    if (i < NUM_SRC) begin : g_cell
      pqsb_cell u_cell (
        .clk(clk), .rst_n(rst_n), .lsi(lsi_mode[i]),
        .bus_hit(bus_act && (dec_src == SRC_W'(i))),
        .bus_op(dec_op), .bus_setv(dec_setv),
        .hw_hit(hw_ok && (hw_src == SRC_W'(i))), .hw_level(hw_level),
        .pq_out(pq_all[i]), .bus_ntf(bntf_all[i]), .hw_ntf(hntf_vec[i])
      );
    end else begin : g_pad
      assign pq_all[i]   = 2'b00;
      assign bntf_all[i] = 1'b0;
      assign hntf_vec[i] = 1'b0;
    end
  end

  assign sel_pq   = pq_all[dec_src];
  assign sel_bntf = bntf_all[dec_src];

  always_comb begin
    case (dec_op)
      OP_EOI:         ld_data = {63'd0, sel_bntf};
      OP_GET, OP_SET: ld_data = {62'd0, sel_pq};
      default:        ld_data = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid      <= 1'b0;
      rd_data       <= '0;
      bus_ntf_valid <= 1'b0;
      bus_ntf_src   <= '0;
      hw_ntf_valid  <= 1'b0;
      hw_ntf_src    <= '0;
    end else begin
      rd_valid      <= bus_valid && !bus_write;
      rd_data       <= ld_data;
      bus_ntf_valid <= sel_bntf;
      bus_ntf_src   <= dec_src;
      hw_ntf_valid  <= |hntf_vec;
      hw_ntf_src    <= hw_src;
    end
  end

endmodule

// File: rtl/pqsb_checker.sv
`timescale 1ns/1ps
module pqsb_checker #(
  parameter int SRC_W      = 4,
  parameter int ADDR_W     = 17,
  parameter int PAGE_SHIFT = 13,
  parameter bit TWO_PAGE   = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        bus_bytes,
  input logic              rd_valid,
  input logic [63:0]       rd_data,
  input logic              bus_ntf_valid,
  input logic              hw_valid,
  input logic [SRC_W-1:0]  hw_src,
  input logic              hw_level,
  input logic              hw_ntf_valid,
  input logic [SRC_W-1:0]  hw_ntf_src,
  input logic              coll_same
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!rd_valid && !bus_ntf_valid && !hw_ntf_valid)); // R1

  AST_NO_BUS_NTF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !bus_ntf_valid); // R2

  AST_TRIG_PAGE_LOAD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (TWO_PAGE && bus_valid && !bus_write && !bus_addr[PAGE_SHIFT-1]) |=> (rd_data == '1)); // R8

  AST_BAD_SIZE_LOAD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_bytes != 4'd8) |=> (rd_data == '1)); // R9

  AST_HW_NTF_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !(hw_valid && hw_level) |=> !hw_ntf_valid); // R10

  AST_HW_NTF_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    hw_valid |=> (!hw_ntf_valid || hw_ntf_src == $past(hw_src))); // R11

  AST_COLLIDE_SINGLE_NTF: assert property (@(posedge clk) disable iff (!rst_n)
    coll_same |=> !(bus_ntf_valid && hw_ntf_valid)); // R12

  AST_LOAD_DATA_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rd_valid); // R13

  AST_NO_DATA_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !rd_valid); // R13

endmodule

bind pq_source_bank pqsb_checker #(
  .SRC_W(SRC_W), .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .TWO_PAGE(TWO_PAGE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_bytes(bus_bytes), .rd_valid(rd_valid), .rd_data(rd_data),
  .bus_ntf_valid(bus_ntf_valid), .hw_valid(hw_valid), .hw_src(hw_src),
  .hw_level(hw_level), .hw_ntf_valid(hw_ntf_valid), .hw_ntf_src(hw_ntf_src),
  .coll_same(coll_same)
);

// File: tb/pq_source_bank_test.sv
`timescale 1ns/1ps
module pq_source_bank_test;

  localparam int NS = 16;
  localparam int SW = 4;
  localparam int AW = 17;
  localparam logic [63:0] ONES = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] lsi_mode = 16'h00F0;
  logic          bus_valid = 1'b0, bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [3:0]    bus_bytes = 4'd0;
  logic          hw_valid = 1'b0, hw_level = 1'b0;
  logic [SW-1:0] hw_src = '0;

  logic          rd_valid, bus_ntf_valid, hw_ntf_valid;
  logic [63:0]   rd_data;
  logic [SW-1:0] bus_ntf_src, hw_ntf_src;
  logic          n_rd_valid, n_bntf_valid, n_hntf_valid;
  logic [63:0]   n_rd_data;
  logic [SW-1:0] n_bntf_src, n_hntf_src;

  always #4 clk = ~clk;

  pq_source_bank uut (
    .clk(clk), .rst_n(rst_n), .lsi_mode(lsi_mode),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr), .bus_bytes(bus_bytes),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .bus_ntf_valid(bus_ntf_valid), .bus_ntf_src(bus_ntf_src),
    .hw_valid(hw_valid), .hw_src(hw_src), .hw_level(hw_level),
    .hw_ntf_valid(hw_ntf_valid), .hw_ntf_src(hw_ntf_src)
  );

  // same stimulus, store-EOI disabled
  pq_source_bank #(.STORE_EOI(1'b0)) uut_nse (
    .clk(clk), .rst_n(rst_n), .lsi_mode(lsi_mode),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr), .bus_bytes(bus_bytes),
    .rd_valid(n_rd_valid), .rd_data(n_rd_data),
    .bus_ntf_valid(n_bntf_valid), .bus_ntf_src(n_bntf_src),
    .hw_valid(hw_valid), .hw_src(hw_src), .hw_level(hw_level),
    .hw_ntf_valid(n_hntf_valid), .hw_ntf_src(n_hntf_src)
  );

  int checks = 0;
  int failures = 0;
  int ncyc = 0;

  // scoreboard: kind 0 = load data, 1 = bus notification, 2 = hw notification
  int          q_kind  [$];
  int          q_stamp [$];
  logic [63:0] q_val   [$];
  string       q_req   [$];

  task automatic push(input int kind, input logic [63:0] v, input string r);
    q_kind.push_back(kind);
    q_stamp.push_back(ncyc + 2);
    q_val.push_back(v);
    q_req.push_back(r);
  endtask

  int          m_k, m_s;
  logic [63:0] m_v, m_a;
  string       m_r;
  logic        m_valid;
  logic [2:0]  m_seen;

  always @(negedge clk) begin
    ncyc = ncyc + 1;
    m_seen = 3'b000;
    while (q_stamp.size() > 0 && q_stamp[0] <= ncyc) begin
      m_k = q_kind.pop_front();
      m_s = q_stamp.pop_front();
      m_v = q_val.pop_front();
      m_r = q_req.pop_front();
      case (m_k)
        0:       begin m_valid = rd_valid;      m_a = rd_data; end
        1:       begin m_valid = bus_ntf_valid; m_a = {60'd0, bus_ntf_src}; end
        default: begin m_valid = hw_ntf_valid;  m_a = {60'd0, hw_ntf_src}; end
      endcase
      checks++;
      if (m_s < ncyc || !m_valid) begin
        failures++;
        $display("FAIL %s (R13 timing) kind=%0d missing: actual valid=%0b expected valid=1 value %h",
                 m_r, m_k, m_valid, m_v);
      end else if (m_a !== m_v) begin
        failures++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", m_r, m_k, m_a, m_v);
      end
      m_seen[m_k] = 1'b1;
    end
    if (rd_valid && !m_seen[0]) begin
      checks++; failures++;
      $display("FAIL R13 unexpected load data: actual valid=1 data=%h expected valid=0", rd_data);
    end
    if (bus_ntf_valid && !m_seen[1]) begin
      checks++; failures++;
      $display("FAIL R2 unexpected bus notification: actual src=%0d expected none", bus_ntf_src);
    end
    if (hw_ntf_valid && !m_seen[2]) begin
      checks++; failures++;
      $display("FAIL R11 unexpected hw notification: actual src=%0d expected none", hw_ntf_src);
    end
  end

  function automatic logic [AW-1:0] mk(input int src, input int page, input logic [11:0] off);
    logic [SW-1:0] s = SW'(src);
    return {s, page[0], off};
  endfunction

  task automatic drive(input logic bv, input logic bw, input logic [AW-1:0] a,
                       input logic [3:0] by, input logic hv, input int hs, input logic hl);
    @(posedge clk);
    #2;
    bus_valid = bv; bus_write = bw; bus_addr = a; bus_bytes = by;
    hw_valid = hv; hw_src = SW'(hs); hw_level = hl;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, '0, 4'd0, 1'b0, 0, 1'b0);
  endtask

  task automatic ld(input int src, input int page, input logic [11:0] off, input logic [3:0] by,
                    input logic [63:0] exp_d, input logic exp_n, input string r);
    drive(1'b1, 1'b0, mk(src, page, off), by, 1'b0, 0, 1'b0);
    push(0, exp_d, r);
    if (exp_n) push(1, 64'(src), r);
  endtask

  task automatic st(input int src, input int page, input logic [11:0] off, input logic [3:0] by,
                    input logic exp_n, input string r);
    drive(1'b1, 1'b1, mk(src, page, off), by, 1'b0, 0, 1'b0);
    if (exp_n) push(1, 64'(src), r);
  endtask

  task automatic hwt(input int src, input logic lvl, input logic exp_n, input string r);
    drive(1'b0, 1'b0, '0, 4'd0, 1'b1, src, lvl);
    if (exp_n) push(2, 64'(src), r);
  endtask

  task automatic get(input int src, input logic [63:0] exp_d, input string r);
    ld(src, 1, 12'h800, 4'd8, exp_d, 1'b0, r);
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL R13 watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (rd_valid || bus_ntf_valid || hw_ntf_valid) begin
      failures++;
      $display("FAIL R1 outputs after reset: actual=%b%b%b expected=000",
               rd_valid, bus_ntf_valid, hw_ntf_valid);
    end

    // R1: every source starts off
    get(0, 1, "R1");
    get(15, 1, "R1");

    // R2: trigger on off does nothing
    hwt(1, 1'b1, 1'b0, "R2");
    get(1, 1, "R2");
    // R6: set load returns old, writes 00
    ld(1, 1, 12'hC00, 4'd8, 1, 1'b0, "R6");
    get(1, 0, "R6");
    // R2: store trigger reset->pending->queued
    st(1, 1, 12'h000, 4'd8, 1'b1, "R2");
    get(1, 2, "R2");
    st(1, 1, 12'h3F8, 4'd8, 1'b0, "R2");
    get(1, 3, "R5");
    // R4 / R3: EOI loads
    ld(1, 1, 12'h000, 4'd8, 1, 1'b1, "R4");
    get(1, 2, "R3");
    ld(1, 1, 12'h7F8, 4'd8, 0, 1'b0, "R4");
    get(1, 0, "R3");

    // R6: set values through stores and loads
    st(2, 1, 12'hF00, 4'd8, 1'b0, "R6");
    get(2, 3, "R6");
    st(2, 1, 12'hD08, 4'd8, 1'b0, "R6");
    get(2, 1, "R6");
    ld(2, 1, 12'hE40, 4'd8, 1, 1'b0, "R6");
    get(2, 2, "R6");

    // R7: store EOI on queued
    st(2, 1, 12'hF00, 4'd8, 1'b0, "R6");
    st(2, 1, 12'h400, 4'd8, 1'b1, "R7");
    get(2, 2, "R7");
    idle();
    @(negedge clk);
    checks++;
    if (n_rd_data !== 64'd3) begin
      failures++;
      $display("FAIL R7 store-EOI disabled not ignored: actual=%h expected=%h", n_rd_data, 64'd3);
    end
    st(2, 1, 12'h400, 4'd8, 1'b0, "R7");
    get(2, 0, "R7");
    st(2, 1, 12'hE00, 4'd8, 1'b0, "R6");
    st(2, 1, 12'h900, 4'd8, 1'b0, "R7");
    get(2, 2, "R7");

    // R8: trigger page
    st(3, 1, 12'hC00, 4'd8, 1'b0, "R6");
    st(3, 0, 12'hC00, 4'd8, 1'b1, "R8");
    get(3, 2, "R8");
    ld(3, 0, 12'h800, 4'd8, ONES, 1'b0, "R8");
    ld(3, 0, 12'h000, 4'd8, ONES, 1'b0, "R8");
    get(3, 2, "R8");

    // R9: illegal sizes
    ld(3, 1, 12'h800, 4'd4, ONES, 1'b0, "R9");
    st(3, 1, 12'hC00, 4'd2, 1'b0, "R9");
    get(3, 2, "R9");

    // R10: level-sensitive source 4
    st(4, 1, 12'hC00, 4'd8, 1'b0, "R6");
    hwt(4, 1'b1, 1'b1, "R10");
    hwt(4, 1'b1, 1'b0, "R10");
    get(4, 2, "R10");
    ld(4, 1, 12'h000, 4'd8, 1, 1'b1, "R10");
    get(4, 2, "R10");
    hwt(4, 1'b0, 1'b0, "R10");
    ld(4, 1, 12'h000, 4'd8, 0, 1'b0, "R10");
    get(4, 0, "R10");

    // R11: message-signalled source 8
    st(8, 1, 12'hC00, 4'd8, 1'b0, "R6");
    hwt(8, 1'b1, 1'b1, "R11");
    hwt(8, 1'b1, 1'b0, "R11");
    hwt(8, 1'b0, 1'b0, "R11");
    get(8, 3, "R11");

    // R12: same-cycle bus and hardware
    st(9, 1, 12'hC00, 4'd8, 1'b0, "R6");
    drive(1'b1, 1'b0, mk(9, 1, 12'h000), 4'd8, 1'b1, 9, 1'b1);
    push(0, 0, "R12");
    push(2, 9, "R12");
    get(9, 2, "R12");
    drive(1'b1, 1'b1, mk(9, 1, 12'hC00), 4'd8, 1'b1, 9, 1'b1);
    push(2, 9, "R12");
    get(9, 2, "R12");
    st(10, 1, 12'hC00, 4'd8, 1'b0, "R6");
    st(11, 1, 12'hC00, 4'd8, 1'b0, "R6");
    drive(1'b1, 1'b1, mk(10, 1, 12'h000), 4'd8, 1'b1, 11, 1'b1);
    push(1, 10, "R12");
    push(2, 11, "R12");
    get(10, 2, "R12");
    get(11, 2, "R12");

    idle();
    repeat (4) @(negedge clk);
    if (q_stamp.size() != 0) begin
      checks++; failures++;
      $display("FAIL R13 leftover expectations: actual=%0d expected=0", q_stamp.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule